// File: doc/BRIEF.md
# Multiplexed External Bus Sequencer

This block turns single requests from an internal master into bus cycles on a multiplexed external bus with a 24-bit address. The address leaves on three byte-wide pin groups: a low group that only ever carries address, a middle group that carries address bits 8 to 15 or the odd data byte, and a high group that carries address bits 16 to 23 or the even data byte. A width-select input picks an 8-bit or a 16-bit external data path. It is sampled together with the wait configuration when a request is accepted. Requests marked internal skip the external bus and go to a local memory port, which is always 16 bits wide.

The sequencer has five states. IDLE accepts a request or grants hold. HOLD keeps the bus released for another master. ADDR drives the full address with the latch strobe high for one cycle. DATA holds the enable strobe low and counts programmed wait cycles and ready stalls. INT performs one transfer on the internal memory port.

The transitions are as follows:
- IDLE goes to HOLD while hold is requested.
- Otherwise IDLE goes to ADDR (external) or INT (internal) when a request is offered.
- HOLD goes to IDLE when hold is released.
- ADDR always goes to DATA.
- DATA goes to ADDR for the second half of a split access, or to IDLE when the transfer ends.
- INT goes to INT for a second half, or to IDLE.

Top module: `ebi_bus_if`

## Requirements
- R1: With `narrow_bus_i` = 1 the external data path is 8 bits. All data moves on the high pin group (`hi_o`/`hi_i`). During the whole data phase the middle group keeps driving address bits 15:8 with `mid_oe_o` = 1.
- R2: With `narrow_bus_i` = 0 the external data path is 16 bits. The byte at the even address uses the high pin group and the byte at the odd address uses the middle pin group. Word data is little-endian: bits 7:0 belong to the lower address.
- R3: An access with `req_internal_i` = 1 produces no latch strobe and no enable strobe. It uses one internal-port cycle per half: `imem_en_o` = 1, `imem_be_o` bit 0 = even byte, bit 1 = odd byte. An even-address word is one cycle with `imem_be_o` = 2'b11 even when `narrow_bus_i` = 1.
- R4: `bhe_n_o` is low in a bus cycle that transfers the odd byte: either the cycle address is odd, or the cycle is an even-address word on the 16-bit path. It is high otherwise.
- R5: `rw_o` is 1 for reads and 0 for writes. `en_n_o` is low only in the data phase and never while `ale_o` is high. In a read data phase the data pin groups are not driven. After reset, `ale_o` = 0, `en_n_o` = 1, `rw_o` = 1, `hlda_n_o` = 1 and `req_ready_o` = 1.
- R6: Each bus cycle starts with `ale_o` high for exactly one cycle. During that cycle the full 24-bit cycle address is on `ad_lo_o`, `mid_o` and `hi_o`. `en_n_o` goes low in the cycle where `ale_o` falls.
- R7: The data phase lasts 1 cycle with `nowait_i` = 1. With `nowait_i` = 0 it lasts 2 cycles when `longwait_i` = 0 and 3 cycles when `longwait_i` = 1. These numbers assume ready stays high.
- R8: Each cycle that `bus_rdy_i` is low at the end of the counted wait time stretches the data phase by one cycle.
- R9: A word at an even address on the 8-bit path is split into two byte cycles, even address first. A word at an odd address is split into two cycles (address A, then A+1) on either path and on the internal port.
- R10: Hold is granted only from IDLE, never in the middle of an access. While `hlda_n_o` = 0, every output enable is low, no strobe is active and `req_ready_o` = 0.
- R11: After `hold_n_i` returns high, `hlda_n_o` is high for at least one cycle before the next latch strobe.
- R12: `rsp_done_o` pulses for one cycle after the last transfer of an access. In that cycle `rsp_rdata_o` holds the read result; a byte read is zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Request accepted this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_word_i | input | 1 | 1 = 16-bit access, 0 = byte |
| req_internal_i | input | 1 | Target is internal memory |
| req_addr_i | input | 24 | Byte address |
| req_wdata_i | input | 16 | Write data (byte in 7:0) |
| rsp_done_o | output | 1 | Access complete pulse |
| rsp_rdata_o | output | 16 | Read result |
| narrow_bus_i | input | 1 | 1 = 8-bit external data, 0 = 16-bit |
| nowait_i | input | 1 | 1 = no programmed wait |
| longwait_i | input | 1 | Selects longer wait variant |
| bus_rdy_i | input | 1 | Low stretches data phase |
| hold_n_i | input | 1 | Low requests bus release |
| hlda_n_o | output | 1 | Low while bus released |
| ale_o | output | 1 | Address latch strobe |
| rw_o | output | 1 | 1 read, 0 write |
| bhe_n_o | output | 1 | Odd byte enable, active low |
| en_n_o | output | 1 | Data enable strobe, active low |
| addr_oe_o | output | 1 | Drive enable for low address group and strobes |
| ad_lo_o | output | 8 | Address bits 7:0 |
| mid_o | output | 8 | Address 15:8 / odd data byte out |
| mid_oe_o | output | 1 | Drive enable for middle group |
| mid_i | input | 8 | Odd data byte in |
| hi_o | output | 8 | Address 23:16 / even data byte out |
| hi_oe_o | output | 1 | Drive enable for high group |
| hi_i | input | 8 | Even data byte in |
| imem_en_o | output | 1 | Internal memory transfer |
| imem_we_o | output | 1 | Internal memory write |
| imem_addr_o | output | 24 | Internal memory byte address |
| imem_be_o | output | 2 | Internal byte enables |
| imem_wdata_o | output | 16 | Internal write data |
| imem_rdata_i | input | 16 | Internal read data (combinational) |

## Verification
The hardest situation to reach from the ports is a hold request that arrives while an access is already under way. The request must be held off until the access ends and then granted with no gap for a new request. The stimulus starts a word access with the long wait variant, so the data phase is wide. It pulls `hold_n_i` low right after the latch strobe, checks that acknowledge stays high through every remaining data cycle, and checks that it drops in the cycle after the completion pulse. A second case holds a request pending throughout an idle hold and checks that at least one acknowledge-high cycle comes before the first strobe.

// File: rtl/ebi_pkg.sv
package ebi_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_ADDR,
        ST_DATA,
        ST_INT
    } ebi_state_e;
endpackage

// File: rtl/ebi_waitgen.sv
// Down-counter for programmed wait cycles of the data phase.
module ebi_waitgen #(
    parameter int CNT_W = 2
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             run_i,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (run_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/ebi_lanes.sv
// Byte-lane steering for writes and byte extraction for reads.
// Even lane = high pin group, odd lane = middle pin group.
module ebi_lanes #(
    parameter int BW = 8
) (
    input  logic          cyc_odd_i,
    input  logic          whole_i,
    input  logic          narrow_i,
    input  logic [BW-1:0] byte_i,
    input  logic [2*BW-1:0] word_i,
    input  logic [BW-1:0] rd_even_i,
    input  logic [BW-1:0] rd_odd_i,
    output logic [BW-1:0] even_dat_o,
    output logic [BW-1:0] odd_dat_o,
    output logic          even_use_o,
    output logic          odd_use_o,
    output logic          bhe_n_o,
    output logic [BW-1:0] rd_byte_o,
    output logic [2*BW-1:0] rd_word_o
);
    always_comb begin
        even_dat_o = '0;
        odd_dat_o  = '0;
        even_use_o = 1'b0;
        odd_use_o  = 1'b0;
        if (whole_i) begin
            even_dat_o = word_i[BW-1:0];
            odd_dat_o  = word_i[2*BW-1:BW];
            even_use_o = 1'b1;
            odd_use_o  = 1'b1;
        end else if (narrow_i || !cyc_odd_i) begin
            even_dat_o = byte_i;
            even_use_o = 1'b1;
        end else begin
            odd_dat_o = byte_i;
            odd_use_o = 1'b1;
        end
    end

    assign bhe_n_o   = !(whole_i || cyc_odd_i);
    assign rd_byte_o = (!narrow_i && cyc_odd_i) ? rd_odd_i : rd_even_i;
    assign rd_word_o = {rd_odd_i, rd_even_i};
endmodule

// File: rtl/ebi_bus_if.sv
module ebi_bus_if
    import ebi_pkg::*;
#(
    parameter int BW         = 8,
    parameter int WAIT_SHORT = 1,
    parameter int WAIT_LONG  = 2
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             req_valid_i,
    output logic             req_ready_o,
    input  logic             req_write_i,
    input  logic             req_word_i,
    input  logic             req_internal_i,
    input  logic [3*BW-1:0]  req_addr_i,
    input  logic [2*BW-1:0]  req_wdata_i,
    output logic             rsp_done_o,
    output logic [2*BW-1:0]  rsp_rdata_o,
    input  logic             narrow_bus_i,
    input  logic             nowait_i,
    input  logic             longwait_i,
    input  logic             bus_rdy_i,
    input  logic             hold_n_i,
    output logic             hlda_n_o,
    output logic             ale_o,
    output logic             rw_o,
    output logic             bhe_n_o,
    output logic             en_n_o,
    output logic             addr_oe_o,
    output logic [BW-1:0]    ad_lo_o,
    output logic [BW-1:0]    mid_o,
    output logic             mid_oe_o,
    input  logic [BW-1:0]    mid_i,
    output logic [BW-1:0]    hi_o,
    output logic             hi_oe_o,
    input  logic [BW-1:0]    hi_i,
    output logic             imem_en_o,
    output logic             imem_we_o,
    output logic [3*BW-1:0]  imem_addr_o,
    output logic [1:0]       imem_be_o,
    output logic [2*BW-1:0]  imem_wdata_o,
    input  logic [2*BW-1:0]  imem_rdata_i
);
    localparam int AW    = 3 * BW;
    localparam int DW    = 2 * BW;
    localparam int CNT_W = $clog2(WAIT_LONG + 1);

    ebi_state_e state_q, state_d;

    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] rdata_q;
    logic          write_q, word_q, int_q, narrow_q, nowait_q, longwait_q;
    logic          phase_q, done_q;

    // Current cycle derivation
    logic [AW-1:0]    cyc_addr;
    logic             narrow_eff, whole, more, xfer_end, accept, wzero;
    logic [BW-1:0]    cur_byte;
    logic [CNT_W-1:0] wait_val;

    assign cyc_addr   = addr_q + AW'(phase_q);
    assign narrow_eff = narrow_q && !int_q;
    assign whole      = word_q && !addr_q[0] && !narrow_eff;
    assign more       = word_q && !whole && !phase_q;
    assign cur_byte   = phase_q ? wdata_q[DW-1:BW] : wdata_q[BW-1:0];
    assign accept     = (state_q == ST_IDLE) && hold_n_i && req_valid_i;
    assign xfer_end   = ((state_q == ST_DATA) && wzero && bus_rdy_i) || (state_q == ST_INT);
    assign wait_val   = nowait_q ? '0 : (longwait_q ? CNT_W'(WAIT_LONG) : CNT_W'(WAIT_SHORT));

    ebi_waitgen #(.CNT_W(CNT_W)) u_wait (
        .clk_i      (clk_i),
        .rst_n_i    (rst_n_i),
        .load_i     (state_q == ST_ADDR),
        .load_val_i (wait_val),
        .run_i      (state_q == ST_DATA),
        .zero_o     (wzero)
    );

    logic [BW-1:0] even_dat, odd_dat, rd_byte, rd_even, rd_odd;
    logic          even_use, odd_use, lane_bhe_n;
    logic [DW-1:0] rd_word;

    assign rd_even = int_q ? imem_rdata_i[BW-1:0]  : hi_i;
    assign rd_odd  = int_q ? imem_rdata_i[DW-1:BW] : mid_i;

    ebi_lanes #(.BW(BW)) u_lanes (
        .cyc_odd_i  (cyc_addr[0]),
        .whole_i    (whole),
        .narrow_i   (narrow_eff),
        .byte_i     (cur_byte),
        .word_i     (wdata_q),
        .rd_even_i  (rd_even),
        .rd_odd_i   (rd_odd),
        .even_dat_o (even_dat),
        .odd_dat_o  (odd_dat),
        .even_use_o (even_use),
        .odd_use_o  (odd_use),
        .bhe_n_o    (lane_bhe_n),
        .rd_byte_o  (rd_byte),
        .rd_word_o  (rd_word)
    );

    // State register
    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!hold_n_i) begin
                    state_d = ST_HOLD;
                end else if (req_valid_i) begin
                    state_d = req_internal_i ? ST_INT : ST_ADDR;
                end
            end
            ST_HOLD: if (hold_n_i) state_d = ST_IDLE;
            ST_ADDR: state_d = ST_DATA;
            ST_DATA: if (wzero && bus_rdy_i) state_d = more ? ST_ADDR : ST_IDLE;
            ST_INT:  state_d = more ? ST_INT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Request capture, phase tracking, read assembly
    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            addr_q     <= '0;
            wdata_q    <= '0;
            rdata_q    <= '0;
            write_q    <= 1'b0;
            word_q     <= 1'b0;
            int_q      <= 1'b0;
            narrow_q   <= 1'b0;
            nowait_q   <= 1'b1;
            longwait_q <= 1'b0;
            phase_q    <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            done_q <= xfer_end && !more;
            if (accept) begin
                addr_q     <= req_addr_i;
                wdata_q    <= req_wdata_i;
                write_q    <= req_write_i;
                word_q     <= req_word_i;
                int_q      <= req_internal_i;
                narrow_q   <= narrow_bus_i;
                nowait_q   <= nowait_i;
                longwait_q <= longwait_i;
                phase_q    <= 1'b0;
            end else if (xfer_end) begin
                if (whole) begin
                    rdata_q <= rd_word;
                end else if (!word_q) begin
                    rdata_q <= {{BW{1'b0}}, rd_byte};
                end else if (!phase_q) begin
                    rdata_q[BW-1:0] <= rd_byte;
                end else begin
                    rdata_q[DW-1:BW] <= rd_byte;
                end
                if (more) phase_q <= 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        ale_o       = 1'b0;
        en_n_o      = 1'b1;
        rw_o        = 1'b1;
        bhe_n_o     = 1'b1;
        addr_oe_o   = 1'b1;
        ad_lo_o     = cyc_addr[BW-1:0];
        mid_o       = cyc_addr[2*BW-1:BW];
        mid_oe_o    = 1'b0;
        hi_o        = cyc_addr[3*BW-1:2*BW];
        hi_oe_o     = 1'b0;
        hlda_n_o    = 1'b1;
        req_ready_o = 1'b0;
        imem_en_o   = 1'b0;
        imem_we_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready_o = hold_n_i;
            ST_HOLD: begin
                addr_oe_o = 1'b0;
                hlda_n_o  = 1'b0;
            end
            ST_ADDR: begin
                ale_o    = 1'b1;
                rw_o     = !write_q;
                bhe_n_o  = lane_bhe_n;
                mid_oe_o = 1'b1;
                hi_oe_o  = 1'b1;
            end
            ST_DATA: begin
                en_n_o  = 1'b0;
                rw_o    = !write_q;
                bhe_n_o = lane_bhe_n;
                if (narrow_eff) begin
                    mid_oe_o = 1'b1;
                end else begin
                    mid_o    = odd_dat;
                    mid_oe_o = write_q;
                end
                hi_o    = even_dat;
                hi_oe_o = write_q;
            end
            ST_INT: begin
                imem_en_o = 1'b1;
                imem_we_o = write_q;
            end
            default: ;
        endcase
    end

    assign imem_addr_o  = cyc_addr;
    assign imem_be_o    = {odd_use, even_use};
    assign imem_wdata_o = {odd_dat, even_dat};
    assign rsp_done_o   = done_q;
    assign rsp_rdata_o  = rdata_q;
endmodule

// File: rtl/ebi_bus_if_chk.sv
module ebi_bus_if_chk (
    input logic clk_i,
    input logic rst_n_i,
    input logic ale_o,
    input logic en_n_o,
    input logic rw_o,
    input logic hlda_n_o,
    input logic addr_oe_o,
    input logic mid_oe_o,
    input logic hi_oe_o,
    input logic req_ready_o,
    input logic rsp_done_o,
    input logic imem_en_o,
    input logic bus_rdy_i
);
    a_r5_no_strobe_overlap: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !(ale_o && !en_n_o));

    a_r5_read_lane_released: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (!en_n_o && rw_o) |-> !hi_oe_o);

    a_r6_data_after_latch: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $fell(ale_o) |-> !en_n_o);

    a_r8_ready_stretch: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (!en_n_o && !bus_rdy_i) |=> !en_n_o);

    a_r3_internal_quiet: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        imem_en_o |-> (en_n_o && !ale_o));

    a_r10_hold_released: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !hlda_n_o |-> (!addr_oe_o && !mid_oe_o && !hi_oe_o && en_n_o && !ale_o && !req_ready_o));

    a_r10_grant_between: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $fell(hlda_n_o) |-> ($past(en_n_o) && !$past(ale_o) && !$past(imem_en_o)));

    a_r11_release_gap: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $rose(ale_o) |-> $past(hlda_n_o));

    a_r12_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        rsp_done_o |=> !rsp_done_o);
endmodule

bind ebi_bus_if ebi_bus_if_chk u_chk (
    .clk_i       (clk_i),
    .rst_n_i     (rst_n_i),
    .ale_o       (ale_o),
    .en_n_o      (en_n_o),
    .rw_o        (rw_o),
    .hlda_n_o    (hlda_n_o),
    .addr_oe_o   (addr_oe_o),
    .mid_oe_o    (mid_oe_o),
    .hi_oe_o     (hi_oe_o),
    .req_ready_o (req_ready_o),
    .rsp_done_o  (rsp_done_o),
    .imem_en_o   (imem_en_o),
    .bus_rdy_i   (bus_rdy_i)
);

// File: tb/ebi_bus_if_tb.sv
`timescale 1ns/1ps
module ebi_bus_if_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0, req_int = 1'b0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        narrow = 1'b0, nowait = 1'b1, longwait = 1'b0, hold_n = 1'b1;
    logic        rdy;
    logic        req_ready, rsp_done, hlda_n, ale, rw, bhe_n, en_n, addr_oe, mid_oe, hi_oe;
    logic        imem_en, imem_we;
    logic [15:0] rsp_rdata, imem_wdata, imem_rdata;
    logic [7:0]  ad_lo, mid_o, hi_o, mid_i, hi_i;
    logic [23:0] imem_addr;
    logic [1:0]  imem_be;

    always #2 clk = ~clk;

    ebi_bus_if dut_i (
        .clk_i(clk), .rst_n_i(rst_n),
        .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
        .req_word_i(req_word), .req_internal_i(req_int), .req_addr_i(req_addr),
        .req_wdata_i(req_wdata), .rsp_done_o(rsp_done), .rsp_rdata_o(rsp_rdata),
        .narrow_bus_i(narrow), .nowait_i(nowait), .longwait_i(longwait),
        .bus_rdy_i(rdy), .hold_n_i(hold_n), .hlda_n_o(hlda_n),
        .ale_o(ale), .rw_o(rw), .bhe_n_o(bhe_n), .en_n_o(en_n), .addr_oe_o(addr_oe),
        .ad_lo_o(ad_lo), .mid_o(mid_o), .mid_oe_o(mid_oe), .mid_i(mid_i),
        .hi_o(hi_o), .hi_oe_o(hi_oe), .hi_i(hi_i),
        .imem_en_o(imem_en), .imem_we_o(imem_we), .imem_addr_o(imem_addr),
        .imem_be_o(imem_be), .imem_wdata_o(imem_wdata), .imem_rdata_i(imem_rdata)
    );

    function automatic logic [7:0] seed(input int i);
        return 8'((i * 37 + 11) ^ 8'h5A);
    endfunction

    // External and internal memory models, written only by the monitor
    logic [7:0]  xmem [256];
    logic [7:0]  imb  [256];
    logic [23:0] lat_addr = '0;
    logic [23:0] lat_log [8];
    logic        bhe_log [8];
    int          ale_cnt = 0, en_cnt = 0, int_cnt = 0, stall_used = 0, stall_goal = 0;
    logic        prev_hlda = 1'b1, gap_bad = 1'b0, mid_bad = 1'b0, rw_last = 1'b1;
    logic [1:0]  be_last = '0;

    assign hi_i  = narrow ? xmem[lat_addr[7:0]] : xmem[{lat_addr[7:1], 1'b0}];
    assign mid_i = xmem[{lat_addr[7:1], 1'b1}];
    assign imem_rdata = {imb[{imem_addr[7:1], 1'b1}], imb[{imem_addr[7:1], 1'b0}]};

    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) begin
                xmem[i] <= seed(i);
                imb[i]  <= seed(i + 100);
            end
            rdy <= 1'b1;
        end else begin
            if (ale) begin
                lat_addr <= {hi_o, mid_o, ad_lo};
                lat_log[ale_cnt[2:0]] <= {hi_o, mid_o, ad_lo};
                bhe_log[ale_cnt[2:0]] <= bhe_n;
                ale_cnt <= ale_cnt + 1;
                if (!prev_hlda) gap_bad <= 1'b1;
            end
            rdy <= 1'b1;
            if (!en_n) begin
                en_cnt  <= en_cnt + 1;
                rw_last <= rw;
                if (narrow && (!mid_oe || mid_o != lat_addr[15:8])) mid_bad <= 1'b1;
                if (!rw) begin
                    if (narrow) begin
                        xmem[lat_addr[7:0]] <= hi_o;
                    end else begin
                        if (!lat_addr[0]) xmem[{lat_addr[7:1], 1'b0}] <= hi_o;
                        if (!bhe_n)       xmem[{lat_addr[7:1], 1'b1}] <= mid_o;
                    end
                end
                if (stall_used < stall_goal) begin
                    rdy <= 1'b0;
                    stall_used <= stall_used + 1;
                end
            end
            if (imem_en) begin
                int_cnt <= int_cnt + 1;
                be_last <= imem_be;
                if (imem_we) begin
                    if (imem_be[0]) imb[{imem_addr[7:1], 1'b0}] <= imem_wdata[7:0];
                    if (imem_be[1]) imb[{imem_addr[7:1], 1'b1}] <= imem_wdata[15:8];
                end
            end
            prev_hlda <= hlda_n;
        end
    end

    int n_checks = 0, n_fail = 0;
    int b_ale, b_en, b_int;
    logic [15:0] rd;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic run_acc(input logic w, input logic wd, input logic intl,
                           input logic [23:0] a, input logic [15:0] wdat,
                           output logic [15:0] res);
        b_ale = ale_cnt; b_en = en_cnt; b_int = int_cnt;
        req_write = w; req_word = wd; req_int = intl; req_addr = a; req_wdata = wdat;
        req_valid = 1'b1;
        step();
        req_valid = 1'b0;
        for (int k = 0; k < 200; k++) begin
            if (rsp_done) break;
            step();
        end
        res = rsp_rdata;
    endtask

    task automatic t_reset();
        check("R5 reset ale", ale, 0);
        check("R5 reset en_n", en_n, 1);
        check("R5 reset rw", rw, 1);
        check("R10 reset hlda_n", hlda_n, 1);
        check("R12 reset ready/done", {req_ready, rsp_done}, 2'b10);
    endtask

    task automatic t_word16_read();
        narrow = 0; nowait = 1;
        run_acc(0, 1, 0, 24'hA5C310, 16'h0, rd);
        check("R2 word16 read data", rd, {seed(8'h11), seed(8'h10)});
        check("R6 one latch pulse", ale_cnt - b_ale, 1);
        check("R6 latched address", lat_log[b_ale[2:0]], 24'hA5C310);
        check("R4 bhe_n even word 16", bhe_log[b_ale[2:0]], 0);
        check("R5 read rw high", rw_last, 1);
        step();
        check("R12 done is one pulse", rsp_done, 0);
    endtask

    task automatic t_word8_read();
        narrow = 1; nowait = 1;
        run_acc(0, 1, 0, 24'h3B7720, 16'h0, rd);
        check("R1 word8 read data", rd, {seed(8'h21), seed(8'h20)});
        check("R9 two cycles on 8-bit", ale_cnt - b_ale, 2);
        check("R9 even address first", lat_log[b_ale[2:0]], 24'h3B7720);
        check("R9 then odd address", lat_log[3'(b_ale + 1)], 24'h3B7721);
        check("R4 bhe_n pair narrow", {bhe_log[b_ale[2:0]], bhe_log[3'(b_ale + 1)]}, 2'b10);
        check("R1 middle group holds address", mid_bad, 0);
    endtask

    task automatic t_odd_word16_write();
        narrow = 0; nowait = 1;
        run_acc(1, 1, 0, 24'h000031, 16'h5566, rd);
        step();
        check("R9 odd word split 16", ale_cnt - b_ale, 2);
        check("R4 bhe_n odd then even", {bhe_log[b_ale[2:0]], bhe_log[3'(b_ale + 1)]}, 2'b01);
        check("R2 odd byte via middle", xmem[8'h31], 8'h66);
        check("R2 even byte via high", xmem[8'h32], 8'h55);
        check("R2 neighbour untouched", xmem[8'h30], seed(8'h30));
        check("R5 write rw low", rw_last, 0);
    endtask

    task automatic t_byte8_write();
        narrow = 1; nowait = 1;
        run_acc(1, 0, 0, 24'h120045, 16'h009A, rd);
        step();
        check("R1 byte write narrow", xmem[8'h45], 8'h9A);
        check("R4 bhe_n odd byte", bhe_log[b_ale[2:0]], 0);
        check("R1 single cycle byte", ale_cnt - b_ale, 1);
        run_acc(0, 0, 0, 24'h120045, 16'h0, rd);
        check("R12 byte read zero-extended", rd, 16'h009A);
    endtask

    task automatic t_waits();
        narrow = 0;
        nowait = 1; longwait = 0;
        run_acc(0, 0, 0, 24'h000040, 16'h0, rd);
        check("R7 no wait length", en_cnt - b_en, 1);
        nowait = 0; longwait = 0;
        run_acc(0, 0, 0, 24'h000040, 16'h0, rd);
        check("R7 short wait length", en_cnt - b_en, 2);
        nowait = 0; longwait = 1;
        run_acc(0, 0, 0, 24'h000040, 16'h0, rd);
        check("R7 long wait length", en_cnt - b_en, 3);
        check("R7 data under wait", rd, {8'h00, seed(8'h40)});
        nowait = 1; longwait = 0;
    endtask

    task automatic t_ready();
        narrow = 0; nowait = 1;
        stall_goal = stall_goal + 3;
        run_acc(0, 1, 0, 24'h000052, 16'h0, rd);
        check("R8 ready stretch length", en_cnt - b_en, 4);
        check("R8 data after stretch", rd, {seed(8'h53), seed(8'h52)});
    endtask

    task automatic t_internal();
        narrow = 1;
        run_acc(0, 1, 1, 24'h000050, 16'h0, rd);
        check("R3 internal read data", rd, {seed(8'h51 + 100), seed(8'h50 + 100)});
        check("R3 no external strobe", {ale_cnt - b_ale, en_cnt - b_en}, 0);
        check("R3 single internal cycle", int_cnt - b_int, 1);
        check("R3 full width enables", be_last, 2'b11);
        run_acc(1, 1, 1, 24'h000061, 16'h7788, rd);
        step();
        check("R9 internal odd word split", int_cnt - b_int, 2);
        check("R3 internal odd byte", imb[8'h61], 8'h88);
        check("R3 internal next byte", imb[8'h62], 8'h77);
    endtask

    task automatic t_hold_idle();
        narrow = 0; nowait = 1;
        hold_n = 0;
        step();
        check("R10 acknowledge in idle", hlda_n, 0);
        check("R10 bus released", {addr_oe, mid_oe, hi_oe, req_ready}, 4'b0000);
        b_ale = ale_cnt;
        req_write = 0; req_word = 1; req_int = 0; req_addr = 24'h000070; req_valid = 1;
        step(); step(); step();
        check("R10 no cycle while held", ale_cnt - b_ale, 0);
        hold_n = 1;
        step();
        check("R11 acknowledge high first", {hlda_n, ale}, 2'b10);
        step();
        req_valid = 0;
        check("R11 latch after release", ale, 1);
        for (int k = 0; k < 50; k++) begin
            if (rsp_done) break;
            step();
        end
        check("R11 gap before strobe", gap_bad, 0);
        check("R11 data after hold", rsp_rdata, {seed(8'h71), seed(8'h70)});
    endtask

    task automatic t_hold_busy();
        int early;
        narrow = 0; nowait = 0; longwait = 1;
        early = 0;
        req_write = 0; req_word = 1; req_int = 0; req_addr = 24'h000084; req_valid = 1;
        step();
        req_valid = 0;
        hold_n = 0;
        for (int k = 0; k < 50; k++) begin
            if (rsp_done) break;
            if (!hlda_n) early++;
            step();
        end
        check("R10 no grant mid access", early, 0);
        check("R10 access completes", rsp_rdata, {seed(8'h85), seed(8'h84)});
        step();
        check("R10 grant after access", hlda_n, 0);
        hold_n = 1;
        step();
        check("R11 release restores", hlda_n, 1);
        nowait = 1; longwait = 0;
    endtask

    initial begin
        #(4 * 100000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_word16_read();
        t_word8_read();
        t_odd_word16_write();
        t_byte8_write();
        t_waits();
        t_ready();
        t_internal();
        t_hold_idle();
        t_hold_busy();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule